// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides one WIDTH-bit integer by another and returns a WIDTH-bit quotient and a WIDTH-bit remainder. It works on unsigned or two's-complement operands, and a per-operation select picks the mode. The division is iterative long division with restoring. In each clock cycle the partial remainder is shifted left by one dividend bit and the divisor is subtracted from it. If the difference is negative, the divisor is added back and the quotient bit is 0. Otherwise the difference is kept and the quotient bit is 1. The partial remainder register is WIDTH+1 bits wide. In signed mode the block divides the magnitudes and then applies signs: the quotient is negated when the operand signs differ, and the remainder takes the sign of the dividend.

Control uses plain pins rather than a stream handshake. The block has no back-pressure. A one-cycle `start` is accepted only while `busy` is low, and `done` pulses for one cycle when the results are ready. The results and the zero-divisor flag hold their values until the next `done`. The block checks for a zero divisor when it accepts `start`, and in that case it answers after a single edge without running any iteration.

Top module: `seq_divider`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `div_zero`, `quotient` and `remainder` are all 0.
- R2: With `is_signed`=0 and a nonzero divisor, the results satisfy dividend = divisor*quotient + remainder, with 0 <= remainder < divisor.
- R3: With `is_signed`=1 (two's complement) and a nonzero divisor, the quotient is truncated toward zero and the remainder has the dividend's sign, with |remainder| < |divisor|.
- R4: For a nonzero divisor, `done` rises WIDTH+1 rising edges after the edge that samples `start`. `busy` is high from the accepting edge until that point.
- R5: `done` is high for exactly one cycle, and `busy` is low whenever `done` is high.
- R6: When the divisor is 0 at the accepting edge, `done` and `div_zero` are high after that same edge, `quotient` is all ones, `remainder` equals the dividend, and `busy` stays low.
- R7: In signed mode, the most negative dividend divided by -1 gives the most negative value as quotient and 0 as remainder, with `div_zero`=0.
- R8: `start` pulses while `busy` is high are ignored: the running operation's results and timing do not change.
- R9: `quotient`, `remainder` and `div_zero` change only on the edge that raises `done`, and otherwise hold their values. A nonzero-divisor completion clears `div_zero`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a division when `busy` is low |
| is_signed | input | 1 | 1 selects two's-complement operands |
| dividend | input | WIDTH | Numerator, sampled with `start` |
| divisor | input | WIDTH | Denominator, sampled with `start` |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle pulse when results are valid |
| div_zero | output | 1 | Last result came from a zero divisor |
| quotient | output | WIDTH | Quotient of the last operation |
| remainder | output | WIDTH | Remainder of the last operation |

## Verification
The bench covers all four sign combinations and checks whether quotient negation and remainder sign follow the right operand. A design that takes the remainder's sign from the divisor, or that floors instead of truncating, gives wrong values for a negative dividend with a positive divisor. The bench also tests the most negative dividend over -1, a maximal unsigned dividend over 1, and equal operands. These expose a magnitude path too narrow to hold 2^(WIDTH-1) and a trial subtraction whose sign bit is lost. The remaining tests cover a zero divisor, where a design that iterates anyway returns late or with the wrong fill values, and a second `start` arriving mid-run, which a careless design would let corrupt the operands.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } div_state_e;

  typedef struct packed {
    logic q_neg;
    logic r_neg;
  } sign_plan_t;

endpackage

// File: rtl/sdiv_magnitude.sv
module sdiv_magnitude
  import sdiv_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] num,
  input  logic [WIDTH-1:0] den,
  input  logic             signed_mode,
  output logic [WIDTH-1:0] num_mag,
  output logic [WIDTH-1:0] den_mag,
  output sign_plan_t       plan
);

  localparam int MSB = WIDTH - 1;

  logic num_neg;
  logic den_neg;

  always_comb begin
    num_neg = signed_mode & num[MSB];
    den_neg = signed_mode & den[MSB];
    // Magnitude of the most negative value is 2^(WIDTH-1), still fits unsigned
    num_mag = num_neg ? (~num + 1'b1) : num;
    den_mag = den_neg ? (~den + 1'b1) : den;
    plan.q_neg = num_neg ^ den_neg;
    plan.r_neg = num_neg;
  end

endmodule

// File: rtl/sdiv_step.sv
module sdiv_step #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH:0]   part_rem,
  input  logic             in_bit,
  input  logic [WIDTH-1:0] den,
  output logic [WIDTH:0]   next_rem,
  output logic             q_bit
);

  localparam int PW = WIDTH + 2;

  logic [WIDTH:0] shifted;
  logic [PW-1:0]  den_ext;
  logic [PW-1:0]  trial;
  logic [PW-1:0]  restored;
  logic           went_neg;

  always_comb begin
    shifted  = {part_rem[WIDTH-1:0], in_bit};
    den_ext  = {2'b00, den};
    trial    = {1'b0, shifted} - den_ext;
    went_neg = trial[PW-1];
    restored = trial + den_ext;
    if (went_neg) begin
      next_rem = restored[WIDTH:0];
      q_bit    = 1'b0;
    end else begin
      next_rem = trial[WIDTH:0];
      q_bit    = 1'b1;
    end
  end

endmodule

// File: rtl/sdiv_sign_fix.sv
module sdiv_sign_fix
  import sdiv_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] q_mag,
  input  logic [WIDTH-1:0] r_mag,
  input  sign_plan_t       plan,
  output logic [WIDTH-1:0] q_out,
  output logic [WIDTH-1:0] r_out
);

  always_comb begin
    q_out = plan.q_neg ? (~q_mag + 1'b1) : q_mag;
    r_out = plan.r_neg ? (~r_mag + 1'b1) : r_mag;
  end

endmodule

// File: rtl/seq_divider.sv
module seq_divider
  import sdiv_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_signed,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic             div_zero,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);

  localparam int CNT_W = $clog2(WIDTH + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WIDTH);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

  div_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [WIDTH:0]   rem_q;
  logic [WIDTH-1:0] quo_q;
  logic [WIDTH-1:0] den_q;
  sign_plan_t       plan_q;

  logic             done_q;
  logic             dz_q;
  logic [WIDTH-1:0] q_res_q;
  logic [WIDTH-1:0] r_res_q;

  logic [WIDTH-1:0] num_mag;
  logic [WIDTH-1:0] den_mag;
  sign_plan_t       plan_in;
  logic [WIDTH:0]   step_rem;
  logic             step_bit;
  logic [WIDTH-1:0] q_fixed;
  logic [WIDTH-1:0] r_fixed;
  logic             accept;
  logic             zero_den;

  sdiv_magnitude #(.WIDTH(WIDTH)) u_mag (
    .num         (dividend),
    .den         (divisor),
    .signed_mode (is_signed),
    .num_mag     (num_mag),
    .den_mag     (den_mag),
    .plan        (plan_in)
  );

  sdiv_step #(.WIDTH(WIDTH)) u_step (
    .part_rem (rem_q),
    .in_bit   (quo_q[WIDTH-1]),
    .den      (den_q),
    .next_rem (step_rem),
    .q_bit    (step_bit)
  );

  // Remainder magnitude is below the divisor, so its top bit is unused here
  sdiv_sign_fix #(.WIDTH(WIDTH)) u_fix (
    .q_mag (quo_q),
    .r_mag (rem_q[WIDTH-1:0]),
    .plan  (plan_q),
    .q_out (q_fixed),
    .r_out (r_fixed)
  );

  assign accept   = start && (state_q == ST_IDLE);
  assign zero_den = (divisor == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rem_q   <= '0;
      quo_q   <= '0;
      den_q   <= '0;
      plan_q  <= '0;
      done_q  <= 1'b0;
      dz_q    <= 1'b0;
      q_res_q <= '0;
      r_res_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (zero_den) begin
              q_res_q <= '1;
              r_res_q <= dividend;
              dz_q    <= 1'b1;
              done_q  <= 1'b1;
            end else begin
              rem_q   <= '0;
              quo_q   <= num_mag;
              den_q   <= den_mag;
              plan_q  <= plan_in;
              cnt_q   <= CNT_LOAD;
              state_q <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          rem_q <= step_rem;
          quo_q <= {quo_q[WIDTH-2:0], step_bit};
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CNT_LAST) begin
            state_q <= ST_FIN;
          end
        end
        ST_FIN: begin
          q_res_q <= q_fixed;
          r_res_q <= r_fixed;
          dz_q    <= 1'b0;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign div_zero  = dz_q;
  assign quotient  = q_res_q;
  assign remainder = r_res_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done longer than one cycle"); // R5

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy) else $error("done while busy"); // R5

  AST_ZERO_DEN_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && divisor == '0) |=> (done && div_zero && !busy))
    else $error("zero divisor not answered at once"); // R6

  AST_REM_BELOW_DEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |-> (rem_q < {1'b0, den_q}))
    else $error("partial remainder not below divisor"); // R2

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(quotient) && $stable(remainder) && $stable(div_zero)))
    else $error("results moved without done"); // R9

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && state_q == ST_RUN && cnt_q != CNT_LAST) |=> (state_q == ST_RUN))
    else $error("run interrupted"); // R8

endmodule

// File: tb/seq_divider_test.sv
module seq_divider_test;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         is_signed = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         busy;
  logic         done;
  logic         div_zero;
  logic [W-1:0] quotient;
  logic [W-1:0] remainder;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  seq_divider #(.WIDTH(W)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .is_signed (is_signed),
    .dividend  (dividend),
    .divisor   (divisor),
    .busy      (busy),
    .done      (done),
    .div_zero  (div_zero),
    .quotient  (quotient),
    .remainder (remainder)
  );

  task automatic check(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic expect_of(input logic [W-1:0] a, input logic [W-1:0] b,
                           input logic sg, output logic [W-1:0] q,
                           output logic [W-1:0] r, output logic dz);
    int sa;
    int sb;
    if (b == '0) begin
      q = '1; r = a; dz = 1'b1;
    end else if (sg) begin
      sa = int'($signed(a));
      sb = int'($signed(b));
      q = W'(sa / sb); r = W'(sa % sb); dz = 1'b0;
    end else begin
      sa = int'(a);
      sb = int'(b);
      q = W'(sa / sb); r = W'(sa % sb); dz = 1'b0;
    end
  endtask

  // Runs one division, checks latency, busy, result and done width
  task automatic run_case(string tag, logic [W-1:0] a, logic [W-1:0] b, logic sg);
    logic [W-1:0] eq;
    logic [W-1:0] er;
    logic         edz;
    int           k;
    int           lat;
    expect_of(a, b, sg, eq, er, edz);
    lat = (b == '0) ? 1 : W + 2;
    @(negedge clk);
    start = 1'b1; dividend = a; divisor = b; is_signed = sg;
    k = 0;
    while (k < 300) begin
      @(negedge clk);
      start = 1'b0;
      k++;
      if (k == 1) check(tag, "busy after accept", longint'(busy), (b == '0) ? 0 : 1);
      if (done) break;
    end
    check(tag, "latency", k, lat);
    check(tag, "quotient", quotient, eq);
    check(tag, "remainder", remainder, er);
    check(tag, "div_zero", div_zero, edz);
    @(negedge clk);
    check("R5", "done one cycle", longint'(done), 0);
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "busy", busy, 0);
    check("R1", "done", done, 0);
    check("R1", "div_zero", div_zero, 0);
    check("R1", "quotient", quotient, 0);
    check("R1", "remainder", remainder, 0);
  endtask

  task automatic test_unsigned();
    run_case("R2", 16'd100, 16'd7, 1'b0);
    run_case("R2", 16'hFFFF, 16'd1, 1'b0);
    run_case("R2", 16'd5, 16'd9, 1'b0);
    run_case("R2", 16'hFFFF, 16'hFFFF, 1'b0);
    run_case("R2", 16'd40000, 16'd3, 1'b0);
    run_case("R4", 16'hFFFE, 16'h8001, 1'b0);
  endtask

  task automatic test_signed();
    run_case("R3", 16'd100, 16'd7, 1'b1);
    run_case("R3", -16'sd100, 16'd7, 1'b1);
    run_case("R3", 16'd100, -16'sd7, 1'b1);
    run_case("R3", -16'sd100, -16'sd7, 1'b1);
    run_case("R3", -16'sd1, 16'd2, 1'b1);
    run_case("R3", 16'h7FFF, 16'h8000, 1'b1);
  endtask

  task automatic test_min_neg();
    run_case("R7", 16'h8000, 16'hFFFF, 1'b1);
    check("R7", "quotient most negative", quotient, 16'h8000);
    run_case("R7", 16'h8000, 16'd1, 1'b1);
  endtask

  task automatic test_zero_div();
    run_case("R6", 16'h1234, 16'h0000, 1'b0);
    run_case("R6", 16'h8765, 16'h0000, 1'b1);
    run_case("R9", 16'd50, 16'd5, 1'b0);
    check("R9", "div_zero cleared", div_zero, 0);
  endtask

  task automatic test_start_while_busy();
    int k;
    @(negedge clk);
    start = 1'b1; dividend = 16'd1000; divisor = 16'd9; is_signed = 1'b0;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    start = 1'b1; dividend = 16'd7; divisor = 16'd0; is_signed = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 6;
    while (k < 300 && !done) begin
      @(negedge clk);
      k++;
    end
    check("R8", "latency kept", k, W + 2);
    check("R8", "quotient", quotient, 16'd111);
    check("R8", "remainder", remainder, 16'd1);
    check("R8", "div_zero", div_zero, 0);
  endtask

  task automatic test_hold();
    logic [W-1:0] q0;
    logic [W-1:0] r0;
    run_case("R9", 16'd12345, 16'd123, 1'b0);
    q0 = quotient; r0 = remainder;
    dividend = 16'd1; divisor = 16'd0;
    repeat (5) @(negedge clk);
    check("R9", "quotient held", quotient, q0);
    check("R9", "remainder held", remainder, r0);
    check("R9", "done low", done, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    test_reset();
    test_unsigned();
    test_signed();
    test_min_neg();
    test_zero_div();
    test_start_while_busy();
    test_hold();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule